// File: doc/BRIEF.md
# Buffered Serial Configuration Port

This block is the serial configuration front end of a frequency synthesizer. A host selects the port with an active-low chip select, then clocks in an instruction byte followed by one to four data bytes on a serial clock. Written words do not reach the synthesizer directly. They go into a shadow buffer, and the whole buffer is copied into the active control registers only when a separate update input shows a rising edge. That edge is sampled against a sync clock that the block produces at one quarter of its system clock, so several devices on one board can commit new settings on the same edge.

The data pin can be set to one of two modes. In 3-wire mode it is an input only, and read data leave on a separate output. In 2-wire mode it is bidirectional, and the block drives it during the data phase of a read. Raising chip select ends a transfer early. An asynchronous port-reset input does the same at once, and the port then ignores serial clocks until chip select has been released. Everything runs on the system clock. The serial pins are oversampled through two-stage synchronizers, so the serial clock must stay well below the system clock (for example 25 Mbit/s against 250 MHz).

Top module: `sio_ctrl_port`

## Requirements
- R1: `sync_clk_o` is a square wave with period DIV (default 4) system clocks: high for DIV/2 cycles and low for DIV/2 cycles.
- R2: A transfer starts with an instruction byte, MSB first. Bit 7 is 1 for read and 0 for write, and bits 4:0 give the address. The number of data bytes is (address mod 4) + 1. Data go MSB first and are sampled on rising serial clock edges. A complete write changes only the shadow buffer: `cfg_o` stays unchanged until a load.
- R3: A rising edge on `update_i` is taken through a two-stage synchronizer and an edge detector, all clocked at the sync clock's rising edges. It produces a load pulse on `load_o` that lasts one system clock and coincides with a rising sync clock. The pulse copies every shadow word into the active registers, and the copies appear on `cfg_o` (register k at bits k*WORD_W upward, right-aligned).
- R4: A read returns the active register value, MSB first, with each new bit launched after a falling serial clock edge. In 3-wire mode the bits come out on `sdo_o` and `sdio_oe_o` stays low.
- R5: In 2-wire mode, read data come out on `sdio_o` with `sdio_oe_o` high during the data phase, and `sdo_o` is held at 0.
- R6: Raising `cs_n_i` before the last data bit of a write drops the partial word. The shadow buffer is left unchanged, and the next transfer starts with a new instruction byte.
- R7: Asserting `port_rst_i` clears `sdio_oe_o`, `sdo_o` and `sdio_o` at once, without waiting for a clock. The transfer in progress is dropped, and serial clocks are ignored until `cs_n_i` has gone high.
- R8: Writes to addresses at or above NREG have no effect. Reads from them return all zeros.
- R9: After `rst_i`, all active and shadow words are zero, and `sdo_o`, `sdio_o` and `sdio_oe_o` are low.
- R10: Holding `update_i` high does not reload. Words written while it stays high are committed only by its next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| port_rst_i | input | 1 | Asynchronous active-high abort of the serial controller |
| cs_n_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Serial data in (pad input side) |
| wire3_i | input | 1 | 1: 3-wire mode, 0: 2-wire mode |
| update_i | input | 1 | Commit strobe; a rising edge loads the shadow buffer |
| sdo_o | output | 1 | Read data output in 3-wire mode |
| sdio_o | output | 1 | Read data for the bidirectional pad in 2-wire mode |
| sdio_oe_o | output | 1 | Output enable for the bidirectional pad |
| sync_clk_o | output | 1 | System clock divided by DIV |
| load_o | output | 1 | One-cycle pulse when the active registers are loaded |
| cfg_o | output | NREG*WORD_W | Active control registers, flattened |

## Verification
The assertions assume that `wire3_i` changes only while chip select is high, and that the serial clock and data are slow enough for each level to last several system clocks, so that no edge is lost in the synchronizers. The bench holds each serial clock phase for six system clocks. It changes data only while the serial clock is low, and it switches the mode only between transfers. The assertions also assume that `update_i` stays at each level for at least three sync clock periods. The bench holds each update level for twenty system clocks or more.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [1:0] {
    ST_ARM,    // waiting for chip select to go high
    ST_IDLE,   // selected, about to take an instruction
    ST_INSTR,  // shifting the instruction byte
    ST_DATA    // shifting data bytes
  } sio_st_e;

  // Data length in bits for an address: (addr mod 4) + 1 bytes.
  function automatic int len_bits(input logic [4:0] a);
    return (int'(a[1:0]) + 1) * 8;
  endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/sio_syncclk.sv
module sio_syncclk #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic sync_clk_o,
  output logic tick_o
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic          sync_q;

  assign cnt_nx = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= LAST;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      sync_q <= (cnt_nx < HALF);
    end
  end

  assign sync_clk_o = sync_q;

endmodule

// File: rtl/sio_update.sv
module sio_update (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic update_i,
  output logic load_o
);

  // sy_q[0], sy_q[1]: synchronizer stages; sy_q[2]: history for edge detect
  logic [2:0] sy_q;
  logic       load_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sy_q   <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (tick_i) begin
        sy_q   <= {sy_q[1:0], update_i};
        load_q <= sy_q[1] & ~sy_q[2];
      end
    end
  end

  assign load_o = load_q;

endmodule

// File: rtl/sio_engine.sv
module sio_engine
  import sio_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              port_rst_i,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  input  logic              wire3_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [ADDR_W-1:0] look_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              sdio_o,
  output logic              sdio_oe_o
);

  localparam int CNT_W = $clog2(WORD_W) + 1;
  localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(7);

  logic [2:0] pins_s;
  logic       cs_s, sclk_s, sdi_s;
  logic       sclk_d;
  logic       rise, fall;

  sio_sync #(.W(3), .RST_VAL(3'b100)) u_pins (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   ({cs_n_i, sclk_i, sdio_i}),
    .q_o   (pins_s)
  );

  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[0];

  always_ff @(posedge clk_i) begin
    if (rst_i) sclk_d <= 1'b0;
    else       sclk_d <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  sio_st_e           st_q;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] out_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  nbits_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_en_q;
  logic [WORD_W-1:0] wr_data_q;
  logic              sdo_q, sdio_q, oe_q;
  logic [WORD_W-1:0] sh_nx;

  // Address bits of the instruction byte as it completes on this edge
  assign look_addr_o = {sh_q[ADDR_W-2:0], sdi_s};
  assign sh_nx       = {sh_q[WORD_W-2:0], sdi_s};

  always_ff @(posedge clk_i or posedge port_rst_i) begin
    if (port_rst_i) begin
      st_q      <= ST_ARM;
      sh_q      <= '0;
      out_q     <= '0;
      cnt_q     <= '0;
      nbits_q   <= '0;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
      sdo_q     <= 1'b0;
      sdio_q    <= 1'b0;
      oe_q      <= 1'b0;
    end else if (rst_i) begin
      st_q      <= ST_ARM;
      sh_q      <= '0;
      out_q     <= '0;
      cnt_q     <= '0;
      nbits_q   <= '0;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
      sdo_q     <= 1'b0;
      sdio_q    <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (cs_s) begin
        st_q   <= ST_IDLE;
        oe_q   <= 1'b0;
        sdo_q  <= 1'b0;
        sdio_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ARM: begin
          end
          ST_IDLE: begin
            st_q  <= ST_INSTR;
            cnt_q <= '0;
            sh_q  <= '0;
          end
          ST_INSTR: begin
            if (rise) begin
              sh_q  <= sh_nx;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == INSTR_LAST) begin
                cnt_q   <= '0;
                sh_q    <= '0;
                rd_q    <= sh_q[6];
                addr_q  <= look_addr_o;
                nbits_q <= CNT_W'(len_bits(look_addr_o));
                out_q   <= rd_word_i << (WORD_W - len_bits(look_addr_o));
                st_q    <= ST_DATA;
              end
            end
          end
          ST_DATA: begin
            if (rd_q && fall) begin
              sdo_q  <= wire3_i & out_q[WORD_W-1];
              sdio_q <= ~wire3_i & out_q[WORD_W-1];
              oe_q   <= ~wire3_i;
              out_q  <= out_q << 1;
            end
            if (rise) begin
              sh_q  <= sh_nx;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == nbits_q - 1'b1) begin
                st_q   <= ST_ARM;
                oe_q   <= 1'b0;
                sdo_q  <= 1'b0;
                sdio_q <= 1'b0;
                if (!rd_q) begin
                  wr_en_q   <= 1'b1;
                  wr_data_q <= sh_nx;
                end
              end
            end
          end
          default: st_q <= ST_ARM;
        endcase
      end
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = wr_data_q;
  assign sdo_o     = sdo_q;
  assign sdio_o    = sdio_q;
  assign sdio_oe_o = oe_q;

endmodule

// File: rtl/sio_ctrl_port.sv
module sio_ctrl_port
  import sio_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int WORD_W = 32,
  parameter int DIV    = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   port_rst_i,
  input  logic                   cs_n_i,
  input  logic                   sclk_i,
  input  logic                   sdio_i,
  input  logic                   wire3_i,
  input  logic                   update_i,
  output logic                   sdo_o,
  output logic                   sdio_o,
  output logic                   sdio_oe_o,
  output logic                   sync_clk_o,
  output logic                   load_o,
  output logic [NREG*WORD_W-1:0] cfg_o
);

  localparam int ADDR_W = 5;
  localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1;

  logic              tick;
  logic              load_p;
  logic [ADDR_W-1:0] look_addr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] rd_word;

  logic [WORD_W-1:0] shadow_q [NREG];
  logic [WORD_W-1:0] active_q [NREG];

  sio_syncclk #(.DIV(DIV)) u_clkgen (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sync_clk_o (sync_clk_o),
    .tick_o     (tick)
  );

  sio_update u_upd (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tick_i   (tick),
    .update_i (update_i),
    .load_o   (load_p)
  );

  sio_engine #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_eng (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .port_rst_i  (port_rst_i),
    .cs_n_i      (cs_n_i),
    .sclk_i      (sclk_i),
    .sdio_i      (sdio_i),
    .wire3_i     (wire3_i),
    .rd_word_i   (rd_word),
    .look_addr_o (look_addr),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .sdo_o       (sdo_o),
    .sdio_o      (sdio_o),
    .sdio_oe_o   (sdio_oe_o)
  );

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          shadow_q[g] <= '0;
          active_q[g] <= '0;
        end else begin
          if (wr_en && (wr_addr == ADDR_W'(g))) shadow_q[g] <= wr_data;
          if (load_p)                           active_q[g] <= shadow_q[g];
        end
      end
      assign cfg_o[g*WORD_W +: WORD_W] = active_q[g];
    end
  endgenerate

  assign rd_word = (int'(look_addr) < NREG) ? active_q[look_addr[IDX_W-1:0]] : '0;
  assign load_o  = load_p;

endmodule

// File: rtl/sio_ctrl_port_chk.sv
module sio_ctrl_port_chk #(
  parameter int NREG   = 8,
  parameter int WORD_W = 32,
  parameter int DIV    = 4
) (
  input logic                   clk_i,
  input logic                   rst_i,
  input logic                   port_rst_i,
  input logic                   wire3_i,
  input logic                   sdo_o,
  input logic                   sdio_o,
  input logic                   sdio_oe_o,
  input logic                   sync_clk_o,
  input logic                   load_o,
  input logic [NREG*WORD_W-1:0] cfg_o
);

  logic       prev_q;
  logic       seen_q;
  logic [7:0] since_q;
  logic       rise_c;

  assign rise_c = sync_clk_o & ~prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q  <= 1'b0;
      seen_q  <= 1'b0;
      since_q <= '0;
    end else begin
      prev_q <= sync_clk_o;
      if (rise_c) begin
        seen_q  <= 1'b1;
        since_q <= 8'd1;
      end else if (since_q != 8'hFF) begin
        since_q <= since_q + 8'd1;
      end
    end
  end

  p_sync_period_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_c && seen_q) |-> (since_q == 8'(DIV)));

  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_o |=> $stable(cfg_o));

  p_load_single_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    load_o |=> !load_o);

  p_load_align_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    load_o |-> rise_c);

  p_oe_mode_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    sdio_oe_o |-> !wire3_i);

  p_sdo_quiet_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !wire3_i |-> !sdo_o);

  p_abort_quiet_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    port_rst_i |-> (!sdio_oe_o && !sdo_o && !sdio_o));

endmodule

bind sio_ctrl_port sio_ctrl_port_chk #(.NREG(NREG), .WORD_W(WORD_W), .DIV(DIV)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .port_rst_i (port_rst_i),
  .wire3_i    (wire3_i),
  .sdo_o      (sdo_o),
  .sdio_o     (sdio_o),
  .sdio_oe_o  (sdio_oe_o),
  .sync_clk_o (sync_clk_o),
  .load_o     (load_o),
  .cfg_o      (cfg_o)
);

// File: tb/sim_sio_ctrl_port.sv
`timescale 1ns/1ps
module sim_sio_ctrl_port;

  localparam int NREG   = 8;
  localparam int WORD_W = 32;
  localparam int DIV    = 4;
  localparam int H      = 6;
  localparam int NVEC   = 6;

  // {address[4:0], data[31:0]}
  localparam logic [36:0] VEC [NVEC] = '{
    {5'd0, 32'h0000_00A5},
    {5'd1, 32'h0000_3C5A},
    {5'd2, 32'h00F0_0F81},
    {5'd3, 32'hDEAD_BEEF},
    {5'd7, 32'h8765_4321},
    {5'd5, 32'h1234_8001}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_rst = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdio_i = 1'b0;
  logic wire3 = 1'b1;
  logic update = 1'b0;
  logic sdo, sdio_o, sdio_oe, sync_clk, load;
  logic [NREG*WORD_W-1:0] cfg;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  sio_ctrl_port #(.NREG(NREG), .WORD_W(WORD_W), .DIV(DIV)) u0 (
    .clk_i      (clk),
    .rst_i      (rst),
    .port_rst_i (port_rst),
    .cs_n_i     (cs_n),
    .sclk_i     (sclk),
    .sdio_i     (sdio_i),
    .wire3_i    (wire3),
    .update_i   (update),
    .sdo_o      (sdo),
    .sdio_o     (sdio_o),
    .sdio_oe_o  (sdio_oe),
    .sync_clk_o (sync_clk),
    .load_o     (load),
    .cfg_o      (cfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [4:0] a);
    return ((a % 4) + 1) * 8;
  endfunction

  function automatic logic [31:0] mask_of(input logic [4:0] a);
    return (nbits_of(a) == 32) ? 32'hFFFF_FFFF : ((32'd1 << nbits_of(a)) - 32'd1);
  endfunction

  function automatic logic [31:0] slot(input int k);
    return cfg[k*WORD_W +: WORD_W];
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cut: data bit index at which chip select rises early (-1: none)
  // prst: data bit index at which the port reset pulses (-1: none)
  task automatic xfer(input bit rd, input logic [4:0] a, input logic [31:0] wd,
                      input int cut, input int prst, output logic [31:0] rdv);
    int nb;
    logic [7:0] ins;
    nb  = nbits_of(a);
    ins = {rd, 2'b00, a};
    rdv = '0;
    cs_n = 1'b0;
    wait_n(H);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; sdio_i = ins[7-i]; wait_n(H);
      sclk = 1'b1; wait_n(H);
    end
    for (int i = 0; i < nb; i++) begin
      if (i == cut) break;
      sclk = 1'b0;
      sdio_i = rd ? 1'b0 : wd[nb-1-i];
      if (i == prst) begin
        wait_n(H/2);
        port_rst = 1'b1;
        #0.5;
        chk("R7 oe cleared by port reset", {31'b0, sdio_oe}, 32'd0);
        chk("R7 outputs cleared by port reset", {30'b0, sdo, sdio_o}, 32'd0);
        wait_n(1);
        port_rst = 1'b0;
        wait_n(H - H/2 - 1);
      end else begin
        wait_n(H);
      end
      if (rd) begin
        rdv = {rdv[30:0], (wire3 ? sdo : sdio_o)};
        if (i == 0 && prst < 0) begin
          if (wire3) chk("R4 oe low in 3-wire read", {31'b0, sdio_oe}, 32'd0);
          else begin
            chk("R5 oe high in 2-wire read", {31'b0, sdio_oe}, 32'd1);
            chk("R5 sdo quiet in 2-wire read", {31'b0, sdo}, 32'd0);
          end
        end
      end
      sclk = 1'b1; wait_n(H);
    end
    sclk = 1'b0; wait_n(H);
    cs_n = 1'b1; wait_n(3*H);
  endtask

  task automatic pulse_update();
    update = 1'b1; wait_n(24);
    update = 1'b0; wait_n(24);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rv;
    int hi, rises;
    logic prev;
    wait_n(5);
    rst = 1'b0;
    wait_n(3);

    // R9: reset state
    chk("R9 cfg zero after reset", {31'b0, |cfg}, 32'd0);
    chk("R9 outputs low after reset", {29'b0, sdo, sdio_o, sdio_oe}, 32'd0);
    xfer(1'b1, 5'd3, '0, -1, -1, rv);
    chk("R9 shadow readback zero", rv, 32'd0);

    // R1: sync clock shape
    hi = 0; rises = 0; prev = sync_clk;
    for (int i = 0; i < 4*DIV; i++) begin
      wait_n(1);
      if (sync_clk) hi++;
      if (sync_clk && !prev) rises++;
      prev = sync_clk;
    end
    chk("R1 sync clock high cycles", hi, 2*DIV);
    chk("R1 sync clock rises", rises, 4);

    // Table walk: write, verify hold, commit, read back (R2, R3, R4, R5)
    for (int v = 0; v < NVEC; v++) begin
      logic [4:0]  a;
      logic [31:0] d;
      a = VEC[v][36:32];
      d = VEC[v][31:0];
      wire3 = 1'b1;
      xfer(1'b0, a, d, -1, -1, rv);
      wait_n(20);
      chk("R2 active unchanged before update", slot(a), 32'd0);
      pulse_update();
      chk("R3 active loaded on update", slot(a), d & mask_of(a));
      wire3 = (v % 2 == 0);
      xfer(1'b1, a, '0, -1, -1, rv);
      chk(wire3 ? "R4 3-wire readback" : "R5 2-wire readback", rv, d & mask_of(a));
    end
    wire3 = 1'b1;

    // R6: early chip-select release drops a partial write
    xfer(1'b0, 5'd3, 32'h1122_3344, 20, -1, rv);
    pulse_update();
    chk("R6 partial write dropped", slot(3), 32'hDEAD_BEEF);
    xfer(1'b0, 5'd3, 32'h1122_3344, -1, -1, rv);
    pulse_update();
    chk("R6 next transfer starts clean", slot(3), 32'h1122_3344);

    // R7: port reset mid write, remaining clocks ignored
    xfer(1'b0, 5'd0, 32'h0000_005A, -1, 3, rv);
    pulse_update();
    chk("R7 aborted write dropped", slot(0), 32'h0000_00A5);
    wire3 = 1'b0;
    xfer(1'b1, 5'd7, '0, -1, 5, rv);
    xfer(1'b1, 5'd7, '0, -1, -1, rv);
    chk("R7 port usable after abort", rv, 32'h8765_4321);
    wire3 = 1'b1;

    // R8: out-of-range address
    xfer(1'b0, 5'd9, 32'h0000_BEEF, -1, -1, rv);
    pulse_update();
    xfer(1'b1, 5'd9, '0, -1, -1, rv);
    chk("R8 out-of-range read is zero", rv, 32'd0);
    chk("R8 reg1 untouched", slot(1), 32'h0000_3C5A);

    // R10: held update does not reload
    xfer(1'b0, 5'd1, 32'h0000_1111, -1, -1, rv);
    update = 1'b1; wait_n(30);
    chk("R10 first edge loads", slot(1), 32'h0000_1111);
    xfer(1'b0, 5'd1, 32'h0000_2222, -1, -1, rv);
    wait_n(30);
    chk("R10 level held: no reload", slot(1), 32'h0000_1111);
    update = 1'b0; wait_n(24);
    chk("R10 falling edge: no reload", slot(1), 32'h0000_1111);
    pulse_update();
    chk("R10 next edge loads", slot(1), 32'h0000_2222);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule